// File: doc/BRIEF.md
# Comparator Output Qualifier

This block turns the raw one-bit result of an analog comparator into clean digital events. The raw result and an optional external sample strobe arrive asynchronously and are brought into the clock domain by synchronizer chains. The synchronized result can be inverted, and it is then qualified by a run-length filter. The filter accepts a new level only after a programmed number of consecutive samples agree. Samples are taken either from an internal period divider or from rising edges of the external strobe.

Either the filtered or the unfiltered level drives the output pin, subject to a pin enable. Changes of the filtered level set sticky rising and falling flags. When their enables are set, these flags raise an interrupt, or a DMA request when DMA mode is on.

A four-entry byte register interface holds the control fields. One entry is opaque storage for analog settings (hysteresis, reference, input selection), which this block does not interpret. Register reads are combinational on the address.

Top module: `cmpf_top`

## Requirements
- R1: The unfiltered level is the raw input, delayed by two clock edges of synchronization and inverted when control bit 3 (invert) is 1.
- R2: With filter count C = control bits 7:5 in 1..7, the filtered level takes a sample's value only once C consecutive samples, counting that sample, have had that same value. C = 1 copies every sample.
- R3: With C = 0 the filtered level equals the unfiltered level when control bit 4 (external sample mode) is 0, and is held at 0 when it is 1.
- R4: In internal mode a sample is taken every P clocks, where P is the byte at address 1. P = 0 stops sampling, and the filtered level then holds.
- R5: In external mode a sample is taken in the cycle after a rising edge of the synchronized strobe. The period divider takes no samples in this mode.
- R6: `cmp_pin` shows the unfiltered level when control bit 2 is 1 and the filtered level when it is 0. It is forced to 0 unless control bits 0 (enable) and 1 (pin enable) are both 1. `cmp_pin_oe` is the AND of those two bits.
- R7: Status bit 1 (rising) and bit 2 (falling) are set one cycle after the filtered level changes 0 to 1 or 1 to 0. They stay set until a 1 is written to them at address 2. A new edge in the same cycle as such a write leaves the flag set.
- R8: The request is (rising AND status bit 3) OR (falling AND status bit 4). It drives `irq` when status bit 5 (DMA mode) is 0 and `dma_req` when that bit is 1, and never both.
- R9: With DMA mode on, a `dma_ack` pulse clears both flags.
- R10: With enable at 0 the filtered level, filter state and both flags are held at 0.
- R11: All fields reset to 0. Address 0 (control), address 1 (period) and address 3 (opaque storage) read back what was written. Address 2 reads {0,0, DMA mode, falling enable, rising enable, falling, rising, filtered level}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Raw comparator result, asynchronous |
| ext_strobe | input | 1 | External sample strobe, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| dma_ack | input | 1 | DMA acknowledge, clears flags in DMA mode |
| cmp_pin | output | 1 | Selected comparator level for the pin |
| cmp_pin_oe | output | 1 | Pin drive enable |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The hardest case to reach is a flag-clearing write that lands in exactly the cycle in which a new edge sets the same flag. The stimulus reaches it in bypass mode (count 0), where the filtered level trails the raw input by a fixed two-edge latency. The write can therefore be scheduled from the moment the raw input changes. Glitches shorter than the programmed run length are produced by holding the raw input for fewer sample periods than the count. A long pseudo-random soak varies every control field while a behavioural model is compared on every clock.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned CNT_W  = 3;
    localparam int unsigned PER_W  = DATA_W;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_AUX  = 2'd3;

    localparam int unsigned ST_RISE = 1;
    localparam int unsigned ST_FALL = 2;

    typedef struct packed {
        logic [CNT_W-1:0] fcount;
        logic             ext_mode;
        logic             invert;
        logic             out_sel;
        logic             pin_en;
        logic             en;
    } ctrl_t;

    typedef struct packed {
        logic dma_en;
        logic fall_ie;
        logic rise_ie;
    } irqcfg_t;
endpackage

// File: rtl/cmpf_sync.sv
module cmpf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cmpf_sampler.sv
module cmpf_sampler #(
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ext_mode,
    input  logic [PER_W-1:0] period,
    input  logic             ext_s,
    output logic             tick
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             ext_prev;
    } samp_t;

    samp_t st_d, st_q;
    logic  int_run, int_tick, ext_tick;

    always_comb begin
        st_d     = st_q;
        int_run  = en && !ext_mode && (period != '0);
        int_tick = int_run && (st_q.cnt >= period - PER_W'(1));
        ext_tick = en && ext_mode && ext_s && !st_q.ext_prev;
        st_d.ext_prev = ext_s;
        if (!int_run || int_tick) st_d.cnt = '0;
        else                      st_d.cnt = st_q.cnt + PER_W'(1);
        tick = int_tick || ext_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cmpf_filter.sv
module cmpf_filter #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             sample,
    input  logic [CNT_W-1:0] need,
    output logic             level
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             cand;
        logic [CNT_W-1:0] run;
        logic             level;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (tick) begin
            if (sample != st_q.cand) begin
                st_d.cand = sample;
                st_d.run  = CNT_W'(1);
            end else if (st_q.run != RUN_MAX) begin
                st_d.run = st_q.run + CNT_W'(1);
            end
            if ((need != '0) && (st_d.run >= need)) st_d.level = sample;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
endmodule

// File: rtl/cmpf_top.sv
module cmpf_top
    import cmpf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_in,
    input  logic              ext_strobe,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dma_ack,
    output logic              cmp_pin,
    output logic              cmp_pin_oe,
    output logic              irq,
    output logic              dma_req
);
    localparam int unsigned N_ASYNC = 2;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [PER_W-1:0]  period;
        irqcfg_t           cfg;
        logic [DATA_W-1:0] aux;
        logic              rise;
        logic              fall;
        logic              prev;
    } top_t;

    top_t st_d, st_q;

    logic [N_ASYNC-1:0] async_in, sync_out;
    logic raw_s, ext_s, unfilt, filt_held, filt, tick;
    logic wr_stat, clr_rise, clr_fall, req_any;

    assign async_in = {ext_strobe, raw_in};

    for (genvar i = 0; i < N_ASYNC; i++) begin : g_sync
        cmpf_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (async_in[i]),
            .q    (sync_out[i])
        );
    end

    assign raw_s = sync_out[0];
    assign ext_s = sync_out[1];

    cmpf_sampler #(.PER_W(PER_W)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (st_q.ctrl.en),
        .ext_mode(st_q.ctrl.ext_mode),
        .period  (st_q.period),
        .ext_s   (ext_s),
        .tick    (tick)
    );

    cmpf_filter #(.CNT_W(CNT_W)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st_q.ctrl.en),
        .tick  (tick),
        .sample(unfilt),
        .need  (st_q.ctrl.fcount),
        .level (filt_held)
    );

    always_comb begin
        st_d   = st_q;
        unfilt = raw_s ^ st_q.ctrl.invert;

        if (!st_q.ctrl.en)                filt = 1'b0;
        else if (st_q.ctrl.fcount == '0)  filt = st_q.ctrl.ext_mode ? 1'b0 : unfilt;
        else                              filt = filt_held;

        wr_stat  = reg_wr && (reg_addr == ADDR_STAT);
        clr_rise = (wr_stat && reg_wdata[ST_RISE]) || (st_q.cfg.dma_en && dma_ack);
        clr_fall = (wr_stat && reg_wdata[ST_FALL]) || (st_q.cfg.dma_en && dma_ack);

        if (reg_wr) begin
            unique case (reg_addr)
                ADDR_CTRL: st_d.ctrl   = ctrl_t'(reg_wdata);
                ADDR_PER:  st_d.period = reg_wdata;
                ADDR_STAT: st_d.cfg    = irqcfg_t'(reg_wdata[5:3]);
                ADDR_AUX:  st_d.aux    = reg_wdata;
                default:   ;
            endcase
        end

        if (!st_q.ctrl.en) begin
            st_d.rise = 1'b0;
            st_d.fall = 1'b0;
            st_d.prev = 1'b0;
        end else begin
            st_d.prev = filt;
            st_d.rise = (st_q.rise && !clr_rise) || (filt && !st_q.prev);
            st_d.fall = (st_q.fall && !clr_fall) || (!filt && st_q.prev);
        end

        req_any = (st_q.rise && st_q.cfg.rise_ie) || (st_q.fall && st_q.cfg.fall_ie);
        irq     = req_any && !st_q.cfg.dma_en;
        dma_req = req_any && st_q.cfg.dma_en;

        cmp_pin_oe = st_q.ctrl.en && st_q.ctrl.pin_en;
        cmp_pin    = cmp_pin_oe && (st_q.ctrl.out_sel ? unfilt : filt);

        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = st_q.ctrl;
            ADDR_PER:  reg_rdata = st_q.period;
            ADDR_STAT: reg_rdata = {2'b00, st_q.cfg, st_q.fall, st_q.rise, filt};
            default:   reg_rdata = st_q.aux;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cmpf_checker.sv
module cmpf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       pin_en,
    input logic [2:0] fcount,
    input logic       tick,
    input logic       unfilt,
    input logic       held,
    input logic       filt,
    input logic       prev,
    input logic       rise,
    input logic       fall,
    input logic       cmp_pin,
    input logic       irq,
    input logic       dma_req
);
    p_req_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma_req));

    p_pin_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |-> !cmp_pin);

    p_rise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && filt && !prev) |=> rise);

    p_fall_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !filt && prev) |=> fall);

    p_hold_between_samples_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(held));

    p_single_sample_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && fcount == 3'd1) |=> (held == $past(unfilt)));

    p_disabled_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!rise && !fall && !held));
endmodule

bind cmpf_top cmpf_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (st_q.ctrl.en),
    .pin_en (st_q.ctrl.pin_en),
    .fcount (st_q.ctrl.fcount),
    .tick   (tick),
    .unfilt (unfilt),
    .held   (filt_held),
    .filt   (filt),
    .prev   (st_q.prev),
    .rise   (st_q.rise),
    .fall   (st_q.fall),
    .cmp_pin(cmp_pin),
    .irq    (irq),
    .dma_req(dma_req)
);

// File: tb/cmpf_top_tb_top.sv
module cmpf_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_in = 1'b0;
    logic       ext_strobe = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd2;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       dma_ack = 1'b0;
    logic       cmp_pin, cmp_pin_oe, irq, dma_req;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R11";
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmpf_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (raw_in),
        .ext_strobe(ext_strobe),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dma_ack   (dma_ack),
        .cmp_pin   (cmp_pin),
        .cmp_pin_oe(cmp_pin_oe),
        .irq       (irq),
        .dma_req   (dma_req)
    );

    // ---------------- behavioural reference model ----------------
    bit   q_raw[$] = '{1'b0, 1'b0};
    bit   q_ext[$] = '{1'b0, 1'b0};
    bit [7:0] m_ctrl = 0, m_per = 0, m_aux = 0;
    bit [2:0] m_cfg = 0;
    int   m_cnt = 0, m_run = 0;
    bit   m_eprev = 0, m_cand = 0, m_out = 0, m_prev = 0, m_rise = 0, m_fall = 0;

    function automatic bit m_unf();
        return q_raw[0] ^ m_ctrl[3];
    endfunction

    function automatic bit m_filt();
        if (!m_ctrl[0]) return 1'b0;
        if (m_ctrl[7:5] == 3'd0) return m_ctrl[4] ? 1'b0 : m_unf();
        return m_out;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q_raw = '{1'b0, 1'b0}; q_ext = '{1'b0, 1'b0};
            m_ctrl = 0; m_per = 0; m_aux = 0; m_cfg = 0; m_cnt = 0; m_run = 0;
            m_eprev = 0; m_cand = 0; m_out = 0; m_prev = 0; m_rise = 0; m_fall = 0;
        end else begin
            bit en, xm, unf, fl, es, tk, clr_r, clr_f, nr, nf;
            int need;
            en = m_ctrl[0]; xm = m_ctrl[4]; need = int'(m_ctrl[7:5]);
            unf = m_unf(); fl = m_filt(); es = q_ext[0];
            tk = (en && !xm && m_per != 0 && m_cnt >= int'(m_per) - 1) ||
                 (en && xm && es && !m_eprev);
            clr_r = (reg_wr && reg_addr == 2'd2 && reg_wdata[1]) || (m_cfg[2] && dma_ack);
            clr_f = (reg_wr && reg_addr == 2'd2 && reg_wdata[2]) || (m_cfg[2] && dma_ack);
            if (!en || xm || m_per == 0 || m_cnt >= int'(m_per) - 1) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            m_eprev = es;
            if (!en) begin
                m_cand = 0; m_run = 0; m_out = 0;
            end else if (tk) begin
                if (unf == m_cand) begin
                    if (m_run < 7) m_run = m_run + 1;
                end else begin
                    m_cand = unf; m_run = 1;
                end
                if (need != 0 && m_run >= need) m_out = unf;
            end
            nr = en && ((m_rise && !clr_r) || (fl && !m_prev));
            nf = en && ((m_fall && !clr_f) || (!fl && m_prev));
            m_rise = nr; m_fall = nf; m_prev = en && fl;
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_ctrl = reg_wdata;
                    2'd1: m_per  = reg_wdata;
                    2'd2: m_cfg  = reg_wdata[5:3];
                    default: m_aux = reg_wdata;
                endcase
            end
            q_raw.push_back(raw_in); void'(q_raw.pop_front());
            q_ext.push_back(ext_strobe); void'(q_ext.pop_front());
        end
    end

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
        end
    endtask

    // compare every cycle, away from the clock edge
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            bit req, pin_oe;
            bit [7:0] rd;
            req = (m_rise && m_cfg[0]) || (m_fall && m_cfg[1]);
            pin_oe = m_ctrl[0] && m_ctrl[1];
            case (reg_addr)
                2'd0: rd = m_ctrl;
                2'd1: rd = m_per;
                2'd2: rd = {2'b00, m_cfg, m_fall, m_rise, m_filt()};
                default: rd = m_aux;
            endcase
            chk({phase, "/R6 pin"}, {7'b0, cmp_pin}, {7'b0, pin_oe && (m_ctrl[2] ? m_unf() : m_filt())});
            chk({phase, "/R6 oe"}, {7'b0, cmp_pin_oe}, {7'b0, pin_oe});
            chk({phase, "/R8 irq"}, {7'b0, irq}, {7'b0, req && !m_cfg[2]});
            chk({phase, "/R8 dma"}, {7'b0, dma_req}, {7'b0, req && m_cfg[2]});
            chk({phase, "/R11 rdata"}, reg_rdata, rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    bit [2:0] cur_cfg = 0;

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd2; reg_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_raw(input bit v, input int hold);
        @(negedge clk); raw_in = v;
        idle(hold);
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); reg_addr = a;
        #3; chk(tag, reg_rdata, exp);
        @(negedge clk); reg_addr = 2'd2;
    endtask

    task automatic strobe(input int gap);
        @(negedge clk); ext_strobe = 1'b1;
        idle(2);
        ext_strobe = 1'b0;
        idle(gap);
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit [15:0] lfsr;
        idle(3);
        @(negedge clk);
        // R11 reset state
        #3;
        chk("R11 reset pins", {4'b0, cmp_pin, cmp_pin_oe, irq, dma_req}, 8'h00);
        rst_n = 1'b1;
        phase = "R11";
        rd_chk(2'd0, 8'h00, "R11 reset ctrl");
        rd_chk(2'd1, 8'h00, "R11 reset period");
        rd_chk(2'd2, 8'h00, "R11 reset status");
        rd_chk(2'd3, 8'h00, "R11 reset aux");
        wr(2'd3, 8'hA5); wr(2'd1, 8'h3C); wr(2'd0, 8'h00);
        rd_chk(2'd3, 8'hA5, "R11 aux readback");
        rd_chk(2'd1, 8'h3C, "R11 period readback");

        // R1: unfiltered path, invert
        phase = "R1";
        wr(2'd0, 8'h07);
        set_raw(1, 1);
        #3; chk("R1 latency not yet", {7'b0, cmp_pin}, 8'h00);
        idle(1);
        #3; chk("R1 unfiltered high", {7'b0, cmp_pin}, 8'h01);
        set_raw(0, 4); set_raw(1, 1); set_raw(0, 5);
        wr(2'd0, 8'h0F);
        idle(3);
        #3; chk("R1 inverted low input", {7'b0, cmp_pin}, 8'h01);
        set_raw(1, 5);

        // R2: run-length filter, internal period 2
        phase = "R2";
        set_raw(0, 2);
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h63);
        idle(10);
        set_raw(1, 3); set_raw(0, 10);
        #3; chk("R2 short glitch rejected", {7'b0, cmp_pin}, 8'h00);
        set_raw(1, 12);
        #3; chk("R2 long run accepted", {7'b0, cmp_pin}, 8'h01);
        wr(2'd0, 8'hE3);
        set_raw(0, 10); set_raw(1, 20); set_raw(0, 20);
        wr(2'd0, 8'h23);
        set_raw(1, 3); set_raw(0, 3); set_raw(1, 5);

        // R4: period zero stops sampling
        phase = "R4";
        wr(2'd1, 8'h00);
        set_raw(0, 12);
        #3; chk("R4 period 0 holds", {7'b0, cmp_pin}, 8'h01);
        wr(2'd1, 8'h01);
        idle(6);
        #3; chk("R4 period 1 resumes", {7'b0, cmp_pin}, 8'h00);
        wr(2'd1, 8'h05);
        set_raw(1, 30); set_raw(0, 30);

        // R3: count zero bypass / forced low
        phase = "R3";
        wr(2'd0, 8'h03);
        set_raw(1, 3);
        #3; chk("R3 bypass follows", {7'b0, cmp_pin}, 8'h01);
        wr(2'd0, 8'h13);
        idle(2);
        #3; chk("R3 forced low", {7'b0, cmp_pin}, 8'h00);

        // R5: external strobe sampling, count 2
        phase = "R5";
        wr(2'd0, 8'h53);
        set_raw(1, 4);
        #3; chk("R5 no strobe no change", {7'b0, cmp_pin}, 8'h00);
        strobe(3); strobe(3);
        #3; chk("R5 two strobes accept", {7'b0, cmp_pin}, 8'h01);
        set_raw(0, 3); strobe(4); set_raw(1, 3); strobe(4); strobe(4);

        // R7: sticky flags, W1C, set beats clear
        phase = "R7";
        set_raw(0, 1);
        wr(2'd0, 8'h03);
        idle(4);
        wr(2'd2, 8'h06);
        rd_chk(2'd2, 8'h00, "R7 flags cleared");
        @(negedge clk); raw_in = 1'b1;
        idle(1);
        wr(2'd2, 8'h02);
        rd_chk(2'd2, 8'h03, "R7 set wins over clear");
        set_raw(0, 4);
        rd_chk(2'd2, 8'h06, "R7 both flags sticky");
        wr(2'd2, 8'h04);
        rd_chk(2'd2, 8'h02, "R7 clear falling only");

        // R8: interrupt / DMA steering
        phase = "R8";
        cur_cfg = 3'b011;
        wr(2'd2, 8'h18);
        #3; chk("R8 irq asserted", {6'b0, irq, dma_req}, 8'h02);
        wr(2'd2, 8'h38);
        #3; chk("R8 dma steered", {6'b0, irq, dma_req}, 8'h01);

        // R9: DMA acknowledge clears
        phase = "R9";
        @(negedge clk); dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0;
        #3; chk("R9 ack cleared", {6'b0, irq, dma_req}, 8'h00);
        set_raw(1, 4);
        @(negedge clk); dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0;

        // R10: disable holds filter and flags at zero
        phase = "R10";
        wr(2'd2, 8'h18);
        set_raw(0, 4);
        wr(2'd0, 8'h02);
        idle(3);
        rd_chk(2'd2, 8'h18, "R10 flags and level held");
        wr(2'd0, 8'h63);
        idle(2);
        rd_chk(2'd2, 8'h18, "R10 filter restarts from zero");

        // soak: pseudo-random mix of every field
        phase = "SOAK-R2R5R7";
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) raw_in = ~raw_in;
            ext_strobe = lfsr[5] & lfsr[7];
            dma_ack = (lfsr[11:8] == 4'hF);
            reg_wr = 1'b0; reg_addr = lfsr[9:8]; reg_wdata = 8'h00;
            if (i % 96 == 0) begin
                reg_wr = 1'b1; reg_addr = 2'd0;
                reg_wdata = {lfsr[15:9], (lfsr[4:0] != 5'd0)};
            end else if (i % 96 == 1) begin
                reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = {5'b0, lfsr[8:6]};
            end else if (i % 96 == 2 || i % 13 == 5) begin
                reg_wr = 1'b1; reg_addr = 2'd2;
                reg_wdata = {2'b00, lfsr[4:0], 1'b0};
            end
        end
        @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd2; dma_ack = 1'b0;
        idle(4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule